// File: doc/BRIEF.md
# Fetch-Execute Control Sequencer

This block is the control state machine of a small 16-bit processor. It owns the program counter, the memory address register and the instruction register. It fetches each instruction word over an external memory bus with a wait-for-ready handshake. It then drives the strobes that move register values through a datapath that lives outside the block.

A two-register arithmetic instruction takes three steps after decode:
- The first register is latched into an operand holding register.
- The second register is placed on the shared bus while the ALU operation is selected, and the result is latched into a result holding register.
- The result is written back to the destination register.

A jump reads its 16-bit target from the word that follows the opcode word. A stop instruction parks the sequencer until reset.

An instruction word holds the following fields:
- bits [15:12]: the opcode.
- bits [11:9]: the destination register.
- bits [8:6]: the source register.
- bits [5:0]: a spare field with no effect.

Top module: `fexec_sequencer`

## Requirements
- R1: While reset is held low and directly after it, `mem_valid`, `ir_load`, `opnd_load`, `res_load`, `rf_write`, `pc_load` and `halted` are 0 and `mem_addr` is 0. The first word fetched after reset comes from address 0.
- R2: Whenever `mem_valid` is 1, `mem_rw` is 0 (read) and `mem_addr` carries the program counter value copied at the start of that access.
- R3: Once `mem_valid` rises, it stays 1 with a stable `mem_addr` until `mem_ready` is seen high. `mem_ready` has no effect while `mem_valid` is 0.
- R4: `ir_load` is 1 only in a cycle where `mem_valid` and `mem_ready` are both 1. `mem_valid` is 0 in the cycle after any such cycle.
- R5: For ADD (opcode 1) and SUB (opcode 2), the sequence runs over three consecutive cycles:
  - `opnd_load` with `rf_rsel` = destination field;
  - `res_load` with `rf_rsel` = source field and `alu_op` = 1 (ADD) or 2 (SUB);
  - `rf_write` with `rf_wsel` = destination field.
- R6: MOV (opcode 3) makes no operand load. It gives `res_load` with `alu_op` = 0 (pass) and `rf_rsel` = source, then `rf_write` to the destination.
- R7: Every accepted instruction fetch raises `pc_load` and advances the program counter by one, so sequential fetches use consecutive addresses.
- R8: JMP (opcode 4) reads the next word as its target. The following instruction fetch uses that target address.
- R9: STOP (opcode 15) sets `halted`, which holds with `mem_valid` at 0 until reset. NOP (opcode 0) and unassigned opcodes return to fetch without any register strobe.
- R10: At most one of `ir_load`, `opnd_load`, `res_load` and `rf_write` is 1 in any cycle. `mem_valid` is 0 whenever one of the last three is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_ready | input | 1 | Memory has placed read data on `mem_rdata` |
| mem_rdata | input | 16 | Read data from memory |
| mem_addr | output | 16 | Address register driving the memory address bus |
| mem_rw | output | 1 | Read/write line, 0 = read |
| mem_valid | output | 1 | Address on `mem_addr` is valid |
| ir_load | output | 1 | Instruction register captures `mem_rdata` |
| opnd_load | output | 1 | Operand register captures the bus |
| res_load | output | 1 | Result register captures the ALU output |
| rf_write | output | 1 | Register file writes the result register |
| pc_load | output | 1 | Program counter takes a new value |
| rf_rsel | output | 3 | Register driven onto the shared bus |
| rf_wsel | output | 3 | Register written by `rf_write` |
| alu_op | output | 2 | ALU function: 0 pass, 1 add, 2 subtract |
| halted | output | 1 | Sequencer is parked after STOP |

## Verification
Capturing the instruction word and advancing the program counter fall in the same cycle whenever `mem_ready` is accepted. The jump target load competes with that same advance in its own memory cycle. Both are provoked by running programs with zero wait states, where ready is granted in the first valid cycle, and with several wait states while `mem_ready` is held high in every idle cycle. A scoreboard judges the outcome by the exact order of fetch addresses and register strobes that the design emits. A skipped, doubled or misdirected program counter update shows up as a wrong next address.

// File: rtl/fexec_seq_pkg.sv
// Package: shared encodings for the fetch-execute sequencer.
// Assumes a 4-bit opcode in the top bits of the instruction word.
package fexec_seq_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_NOP  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_ADD  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_SUB  = 4'd2;
    localparam logic [OPC_W-1:0] OPC_MOV  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_JMP  = 4'd4;
    localparam logic [OPC_W-1:0] OPC_STOP = 4'd15;

    localparam logic [1:0] ALU_PASS = 2'd0;
    localparam logic [1:0] ALU_ADD  = 2'd1;
    localparam logic [1:0] ALU_SUB  = 2'd2;

    typedef enum logic [2:0] {
        SQ_FETCH,   // copy PC into address register
        SQ_FWAIT,   // instruction read, wait for ready
        SQ_DECODE,  // inspect opcode, first operand step
        SQ_EXEC,    // second operand on bus, result latched
        SQ_WBACK,   // result to destination register
        SQ_JWAIT,   // jump target read, wait for ready
        SQ_HALT     // parked until reset
    } seq_state_e;

endpackage

// File: rtl/fexec_addr_unit.sv
// Module: program counter and memory address register.
// The PC advances by one or loads a jump target; the address register
// copies the PC on request. Assumes the increment and the jump are never
// requested together (the sequencer guarantees this).
module fexec_addr_unit #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_load,
    input  logic              pc_inc,
    input  logic              pc_jump,
    input  logic [ADDR_W-1:0] jump_tgt,
    output logic [ADDR_W-1:0] ar_q
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;

    // Program counter update: reset to 0, step or jump.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (pc_jump)
            pc_q <= jump_tgt;
        else if (pc_inc)
            pc_q <= pc_q + PC_STEP;
    end

    // Address register: captures the PC at the start of each read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ar_q <= '0;
        else if (ar_load)
            ar_q <= pc_q;
    end

endmodule

// File: rtl/fexec_instr_reg.sv
// Module: instruction register with field split.
// Holds only the opcode and both register-select fields; the spare
// low field of the word is never stored.
module fexec_instr_reg #(
    parameter int SEL_W = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ir_load,
    input  logic [fexec_seq_pkg::OPC_W+2*SEL_W-1:0] word_hi,
    output logic [fexec_seq_pkg::OPC_W-1:0]       opcode,
    output logic [SEL_W-1:0]                      dst_sel,
    output logic [SEL_W-1:0]                      src_sel
);

    localparam int IR_W = fexec_seq_pkg::OPC_W + 2 * SEL_W;

    logic [IR_W-1:0] ir_q;

    // Capture the upper instruction fields when memory data is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ir_q <= '0;
        else if (ir_load)
            ir_q <= word_hi;
    end

    // Field split: opcode on top, then destination, then source.
    always_comb begin
        opcode  = ir_q[IR_W-1 -: fexec_seq_pkg::OPC_W];
        dst_sel = ir_q[2*SEL_W-1 -: SEL_W];
        src_sel = ir_q[SEL_W-1:0];
    end

endmodule

// File: rtl/fexec_fsm.sv
// Module: sequencing state machine.
// Drives the memory handshake and every load strobe from the current
// state and the decoded opcode. Outputs are combinational from state,
// so the valid strobe falls in the cycle after ready is accepted.
module fexec_fsm #(
    parameter int SEL_W = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            mem_ready,
    input  logic [fexec_seq_pkg::OPC_W-1:0] opcode,
    input  logic [SEL_W-1:0]                dst_sel,
    input  logic [SEL_W-1:0]                src_sel,
    output logic                            mem_valid,
    output logic                            mem_rw,
    output logic                            ar_load,
    output logic                            pc_inc,
    output logic                            pc_jump,
    output logic                            ir_load,
    output logic                            opnd_load,
    output logic                            res_load,
    output logic                            rf_write,
    output logic [SEL_W-1:0]                rf_rsel,
    output logic [SEL_W-1:0]                rf_wsel,
    output logic [1:0]                      alu_op,
    output logic                            halted
);

    import fexec_seq_pkg::*;

    seq_state_e state_q, state_d;

    // State register with synchronous reset into fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SQ_FETCH;
        else
            state_q <= state_d;
    end

    // Next state and strobe decode.
    always_comb begin
        state_d   = state_q;
        mem_valid = 1'b0;
        ar_load   = 1'b0;
        pc_inc    = 1'b0;
        pc_jump   = 1'b0;
        ir_load   = 1'b0;
        opnd_load = 1'b0;
        res_load  = 1'b0;
        rf_write  = 1'b0;
        rf_rsel   = dst_sel;
        alu_op    = ALU_PASS;
        unique case (state_q)
            SQ_FETCH: begin
                ar_load = 1'b1;
                state_d = SQ_FWAIT;
            end
            SQ_FWAIT: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    ir_load = 1'b1;
                    pc_inc  = 1'b1;
                    state_d = SQ_DECODE;
                end
            end
            SQ_DECODE: begin
                case (opcode)
                    OPC_ADD, OPC_SUB: begin
                        opnd_load = 1'b1;
                        rf_rsel   = dst_sel;
                        state_d   = SQ_EXEC;
                    end
                    OPC_MOV:  state_d = SQ_EXEC;
                    OPC_JMP: begin
                        ar_load = 1'b1;
                        state_d = SQ_JWAIT;
                    end
                    OPC_STOP: state_d = SQ_HALT;
                    default:  state_d = SQ_FETCH;
                endcase
            end
            SQ_EXEC: begin
                res_load = 1'b1;
                rf_rsel  = src_sel;
                if (opcode == OPC_ADD)
                    alu_op = ALU_ADD;
                else if (opcode == OPC_SUB)
                    alu_op = ALU_SUB;
                else
                    alu_op = ALU_PASS;
                state_d = SQ_WBACK;
            end
            SQ_WBACK: begin
                rf_write = 1'b1;
                state_d  = SQ_FETCH;
            end
            SQ_JWAIT: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    pc_jump = 1'b1;
                    state_d = SQ_FETCH;
                end
            end
            SQ_HALT: state_d = SQ_HALT;
            default: state_d = SQ_FETCH;
        endcase
    end

    // Fixed outputs: no store instruction exists, destination always from IR.
    always_comb begin
        mem_rw  = 1'b0;
        rf_wsel = dst_sel;
        halted  = (state_q == SQ_HALT);
    end

endmodule

// File: rtl/fexec_sequencer.sv
// Module: top of the fetch-execute control sequencer.
// Joins the address unit, instruction register and state machine.
// Assumes the address width does not exceed the data width, since a
// jump target is one memory word.
module fexec_sequencer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rw,
    output logic              mem_valid,
    output logic              ir_load,
    output logic              opnd_load,
    output logic              res_load,
    output logic              rf_write,
    output logic              pc_load,
    output logic [SEL_W-1:0]  rf_rsel,
    output logic [SEL_W-1:0]  rf_wsel,
    output logic [1:0]        alu_op,
    output logic              halted
);

    localparam int IR_W = fexec_seq_pkg::OPC_W + 2 * SEL_W;

    logic                            ar_load, pc_inc, pc_jump;
    logic [fexec_seq_pkg::OPC_W-1:0] opcode;
    logic [SEL_W-1:0]                dst_sel, src_sel;

    fexec_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ar_load  (ar_load),
        .pc_inc   (pc_inc),
        .pc_jump  (pc_jump),
        .jump_tgt (mem_rdata[ADDR_W-1:0]),
        .ar_q     (mem_addr)
    );

    fexec_instr_reg #(.SEL_W(SEL_W)) u_ir (
        .clk     (clk),
        .rst_n   (rst_n),
        .ir_load (ir_load),
        .word_hi (mem_rdata[DATA_W-1 -: IR_W]),
        .opcode  (opcode),
        .dst_sel (dst_sel),
        .src_sel (src_sel)
    );

    fexec_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_ready (mem_ready),
        .opcode    (opcode),
        .dst_sel   (dst_sel),
        .src_sel   (src_sel),
        .mem_valid (mem_valid),
        .mem_rw    (mem_rw),
        .ar_load   (ar_load),
        .pc_inc    (pc_inc),
        .pc_jump   (pc_jump),
        .ir_load   (ir_load),
        .opnd_load (opnd_load),
        .res_load  (res_load),
        .rf_write  (rf_write),
        .rf_rsel   (rf_rsel),
        .rf_wsel   (rf_wsel),
        .alu_op    (alu_op),
        .halted    (halted)
    );

    // Program counter load strobe for the datapath view.
    always_comb pc_load = pc_inc | pc_jump;

endmodule

// File: rtl/fexec_sequencer_chk.sv
// Module: protocol checker for the sequencer, bound to its top.
// Observes ports only.
module fexec_sequencer_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_ready,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ir_load,
    input logic              opnd_load,
    input logic              res_load,
    input logic              rf_write,
    input logic              halted
);

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R3

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> !mem_valid); // R4

    AST_IR_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |-> (mem_valid && mem_ready)); // R4

    AST_OPND_TO_RES: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_load |=> res_load); // R5

    AST_RES_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        res_load |=> rf_write); // R5

    AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_valid)); // R9

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ir_load, opnd_load, res_load, rf_write})); // R10

    AST_NO_VALID_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_load || res_load || rf_write) |-> !mem_valid); // R10

endmodule

bind fexec_sequencer fexec_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .ir_load   (ir_load),
    .opnd_load (opnd_load),
    .res_load  (res_load),
    .rf_write  (rf_write),
    .halted    (halted)
);

// File: tb/sim_fexec_sequencer.sv
`timescale 1ns/1ps
// Bench: scoreboard over the sequencer's memory and strobe traffic.
module sim_fexec_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_RD = 2'd0, K_OPND = 2'd1, K_EXEC = 2'd2, K_WB = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem_addr;
    logic        mem_rw, mem_valid, ir_load, opnd_load, res_load, rf_write, pc_load, halted;
    logic [2:0]  rf_rsel, rf_wsel;
    logic [1:0]  alu_op;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit running = 1'b0;
    int lat_cfg = 0;
    bit stuck_cfg = 1'b0;
    int wcnt = 0;
    logic [15:0] mem [64];
    logic [17:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fexec_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rw(mem_rw), .mem_valid(mem_valid),
        .ir_load(ir_load), .opnd_load(opnd_load), .res_load(res_load),
        .rf_write(rf_write), .pc_load(pc_load), .rf_rsel(rf_rsel),
        .rf_wsel(rf_wsel), .alu_op(alu_op), .halted(halted)
    );

    // Memory model: ready after lat_cfg wait cycles; optionally stuck high when idle.
    always @(negedge clk) begin
        if (!rst_n) begin
            wcnt = 0;
            mem_ready <= 1'b0;
        end else if (mem_valid) begin
            if (wcnt >= lat_cfg) begin
                mem_ready <= 1'b1;
                mem_rdata <= mem[mem_addr[5:0]];
            end else begin
                mem_ready <= 1'b0;
                mem_rdata <= 16'hDEAD;
            end
            wcnt = wcnt + 1;
        end else begin
            wcnt = 0;
            mem_ready <= stuck_cfg;
            mem_rdata <= 16'hBEEF;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string kind_req(input logic [1:0] k);
        case (k)
            K_RD:    return "R2/R7/R8 fetch address";
            K_OPND:  return "R5 operand step";
            K_EXEC:  return "R5/R6 execute step";
            default: return "R5/R6 write-back step";
        endcase
    endfunction

    // Monitor: classify each cycle's event and compare with the queue head.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && running) begin
            logic [17:0] ev;
            bit have;
            have = 1'b1;
            if (mem_valid && mem_ready) begin
                ev = {K_RD, mem_addr};
                check("R4 ir_load with ready", {31'b0, ir_load | pc_load}, 32'd1);
                check("R2 read line low", {31'b0, mem_rw}, 32'd0);
            end else if (opnd_load) ev = {K_OPND, 13'b0, rf_rsel};
            else if (res_load)      ev = {K_EXEC, 11'b0, alu_op, rf_rsel};
            else if (rf_write)      ev = {K_WB, 13'b0, rf_wsel};
            else have = 1'b0;
            if (!mem_ready && ir_load) check("R3 ir_load without ready", 32'd1, 32'd0);
            if ((opnd_load || res_load || rf_write) && mem_valid)
                check("R10 valid during execute", 32'd1, 32'd0);
            if (have) begin
                if (exp_q.size() == 0) begin
                    check({kind_req(ev[17:16]), " unexpected"}, {14'b0, ev}, 32'h3FFFF);
                end else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    check(kind_req(e[17:16]), {14'b0, ev}, {14'b0, e});
                end
            end
        end
    end

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] d, input logic [2:0] s);
        return {op, d, s, 6'h2A};
    endfunction

    task automatic exp_fetch(input logic [15:0] a);
        exp_q.push_back({K_RD, a});
    endtask

    task automatic exp_arith(input logic [1:0] op, input logic [2:0] d, input logic [2:0] s);
        exp_q.push_back({K_OPND, 13'b0, d});
        exp_q.push_back({K_EXEC, 11'b0, op, s});
        exp_q.push_back({K_WB, 13'b0, d});
    endtask

    task automatic exp_mov(input logic [2:0] d, input logic [2:0] s);
        exp_q.push_back({K_EXEC, 11'b0, 2'd0, s});
        exp_q.push_back({K_WB, 13'b0, d});
    endtask

    // Driver: reset, check idle outputs, run to halt, check halt holds.
    task automatic run_prog(input int lat, input bit stuck);
        lat_cfg = lat;
        stuck_cfg = stuck;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check("R1 reset addr", {16'b0, mem_addr}, 32'd0);
        check("R1 reset strobes",
              {25'b0, mem_valid, ir_load, opnd_load, res_load, rf_write, pc_load, halted}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        #2;
        check("R1 idle after reset", {30'b0, mem_valid, halted}, 32'd0);
        for (int i = 0; i < 600 && !halted; i++) @(negedge clk);
        check("R9 reached halt", {31'b0, halted}, 32'd1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            #2;
            check("R9 halt holds, valid low", {30'b0, halted, mem_valid}, 32'd2);
        end
        check("R9 all expected events seen", exp_q.size(), 32'd0);
        running = 1'b0;
        exp_q.delete();
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // Program A: ALU ops, MOV, NOP, jump, unassigned opcode, STOP.
        for (int i = 0; i < 64; i++) mem[i] = 16'hF000;
        mem[0]  = enc(4'd1, 3'd1, 3'd2);
        mem[1]  = enc(4'd2, 3'd3, 3'd4);
        mem[2]  = enc(4'd3, 3'd5, 3'd6);
        mem[3]  = enc(4'd0, 3'd7, 3'd7);
        mem[4]  = enc(4'd4, 3'd0, 3'd0);
        mem[5]  = 16'd10;
        mem[10] = enc(4'd7, 3'd2, 3'd3);
        mem[11] = enc(4'd1, 3'd7, 3'd0);
        mem[12] = enc(4'd15, 3'd0, 3'd0);
        for (int pass = 0; pass < 2; pass++) begin
            exp_fetch(16'd0);  exp_arith(2'd1, 3'd1, 3'd2);   // R5 ADD, R1 first fetch at 0
            exp_fetch(16'd1);  exp_arith(2'd2, 3'd3, 3'd4);   // R5 SUB
            exp_fetch(16'd2);  exp_mov(3'd5, 3'd6);           // R6 MOV
            exp_fetch(16'd3);                                 // R9 NOP
            exp_fetch(16'd4);  exp_fetch(16'd5);              // R8 JMP target word
            exp_fetch(16'd10);                                // R8 target, R9 unassigned
            exp_fetch(16'd11); exp_arith(2'd1, 3'd7, 3'd0);   // R7 sequential after jump
            exp_fetch(16'd12);                                // R9 STOP
            if (pass == 0) run_prog(0, 1'b0);                 // zero wait states
            else           run_prog(3, 1'b1);                 // R3 waits, ready stuck when idle
        end
        // Program B: jump first, then MOV and SUB at the target.
        mem[0]  = enc(4'd4, 3'd0, 3'd0);
        mem[1]  = 16'h0030;
        mem[48] = enc(4'd3, 3'd0, 3'd7);
        mem[49] = enc(4'd2, 3'd6, 3'd6);
        mem[50] = enc(4'd15, 3'd0, 3'd0);
        exp_fetch(16'd0);  exp_fetch(16'd1);                  // R8
        exp_fetch(16'd48); exp_mov(3'd0, 3'd7);               // R6
        exp_fetch(16'd49); exp_arith(2'd2, 3'd6, 3'd6);       // R5
        exp_fetch(16'd50);                                    // R9
        run_prog(1, 1'b1);
        finish_run();
    end

endmodule